// File: doc/BRIEF.md
# Edge-Latched Byte Memory Controller

This block is the device-side control and storage for a byte-wide memory reached over an asynchronous parallel bus. It has active-low chip-enable, write-enable and output-enable pins, an address bus and a byte-wide data path. Inside the chip the data path is split into an input, an output and a drive-enable, which feed a tristate pad. All pins are oversampled by a reference clock. The address is taken only at an accepted falling edge of chip enable, and every read and write in that access uses the captured address. Address movement while chip enable stays low has no effect.

A write starts in one of two ways. In an early write, write enable is already low when chip enable falls. In a late write, write enable falls while chip enable is low. In both cases the data byte is taken into an internal holding register at that event and stored on the next cycle. While chip enable is low and write enable is high, the access is a read. The stored byte is put on the bus only when output enable allows it.

The captured address is split into a row field, a column field and a block field. The block field selects one of several storage banks. After chip enable rises, a precharge interval of reference-clock cycles must pass. A falling edge that comes too early is refused and flagged.

Top module: `latched_mem`

## Requirements
- R1: The block stores 2^(ROW_W+COL_W+BLK_W) independent bytes. The default is 2048 (BLK_W=1). BLK_W=5 gives 32,768 bytes on a 15-bit address. A byte written at one address is read back unchanged, and no other address is disturbed.
- R2: The address is captured at an accepted falling edge of ceN. Address changes while ceN stays low do not change which location is read or written.
- R3: While ceN is high, nothing is written and dqDrive stays 0, whatever the state of oeN and weN.
- R4: Early write: if weN is low when an accepted ceN fall is sampled, dqIn sampled at that same clock is stored at the captured address.
- R5: Late write: a falling edge of weN while ceN is low stores the dqIn value sampled at that edge. Later changes of dqIn have no effect.
- R6: Read: with ceN low, weN high and oeN low, dqDrive is 1 and dqOut carries the byte stored at the captured address. This holds no later than 4 clock cycles after the pins settle, including right after a write in the same access.
- R7: oeN only gates the output. With oeN high, dqDrive is 0. Writes take effect whatever the level of oeN.
- R8: dqDrive stays 0 whenever weN is low, even with oeN low.
- R9: Address bits [ROW_W-1:0] are the row, the next COL_W bits are the column, and the top BLK_W bits select the bank. Addresses that differ in only one field reach distinct locations.
- R10: A ceN fall is accepted only after ceN has been sampled high for at least PRECHARGE_CYC consecutive clocks (default 4). An earlier fall raises prechargeErr until ceN rises. In that access nothing is written and dqDrive stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that samples the bus pins |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip enable; its fall starts an access |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| addr | input | ROW_W+COL_W+BLK_W | Byte address |
| dqIn | input | DATA_W | Data arriving from the bus |
| dqOut | output | DATA_W | Data to the bus; zero when not driving |
| dqDrive | output | 1 | Output driver enable for the data pad |
| prechargeErr | output | 1 | High while an access refused for short precharge is pending |

## Verification
The bench moves the address after every ceN fall, and in late writes it changes dqIn right after the weN edge. A design that followed the live address or the live data would read back bytes from the wrong location. Early and late writes are mixed with reads, each read is followed by an address wiggle, and every read is compared with a model array. A design that missed the early-write case, or served a stale byte right after a write, would therefore fail. Output enable is held low during writes and high during some reads, which exposes bus contention and any dependence of writes on oeN. A too-short ceN high pulse is followed by write attempts. A design that accepted the access would raise no error flag and would corrupt the stored byte.

// File: rtl/latched_mem_pkg.sv
package latched_mem_pkg;

  typedef struct packed {
    logic latchAddr;
    logic captureData;
    logic commit;
    logic readEn;
  } ctrlStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_REJECT = 2'd2
  } accStateT;

endpackage

// File: rtl/latched_mem_sync.sv
module latched_mem_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stg[i] <= RST_VAL;
          else       stg[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stg[i] <= RST_VAL;
          else       stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/latched_mem_ctrl.sv
module latched_mem_ctrl
  import latched_mem_pkg::*;
#(
  parameter int PRECHARGE_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceS,
  input  logic       weS,
  input  logic       oeS,
  output ctrlStrobeT strb,
  output logic       dqDrive,
  output logic       prechargeErr
);

  localparam int CNT_W = $clog2(PRECHARGE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PRECHARGE_CYC);

  accStateT          state, stateNext;
  logic              cePrev, wePrev;
  logic              commitQ, rdValidQ;
  logic [CNT_W-1:0]  preCnt;
  logic              ceFall, weFall, accept;

  assign ceFall = cePrev & ~ceS;
  assign weFall = wePrev & ~weS;
  assign accept = ceFall & (preCnt >= CNT_MAX);

  // Access state machine
  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (ceFall) stateNext = accept ? ST_ACTIVE : ST_REJECT;
      ST_ACTIVE: if (ceS) stateNext = ST_IDLE;
      ST_REJECT: if (ceS) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cePrev   <= 1'b1;
      wePrev   <= 1'b1;
      commitQ  <= 1'b0;
      rdValidQ <= 1'b0;
      preCnt   <= CNT_MAX;
    end else begin
      state    <= stateNext;
      cePrev   <= ceS;
      wePrev   <= weS;
      commitQ  <= strb.captureData;
      rdValidQ <= strb.readEn;
      if (ceS) preCnt <= (preCnt == CNT_MAX) ? preCnt : preCnt + 1'b1;
      else     preCnt <= '0;
    end
  end

  // Strobes to the datapath
  always_comb begin
    strb.latchAddr   = (state == ST_IDLE) & accept;
    strb.captureData = ((state == ST_IDLE) & accept & ~weS)
                     | ((state == ST_ACTIVE) & weFall & ~ceS);
    strb.commit      = commitQ;
    strb.readEn      = (state == ST_ACTIVE) & ~ceS & weS & ~commitQ;
  end

  assign dqDrive      = (state == ST_ACTIVE) & ~ceS & weS & ~oeS & rdValidQ;
  assign prechargeErr = (state == ST_REJECT);

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ceS && cePrev) |-> (!strb.commit && !strb.latchAddr && !dqDrive)); // R3

  AST_REJECT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REJECT) |-> (!strb.captureData && !strb.latchAddr && !dqDrive)); // R10

  AST_EARLY_FALL_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (ceFall && (preCnt < CNT_MAX)) |=> prechargeErr); // R10

  AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    dqDrive |-> (!strb.commit && !strb.captureData)); // R8

endmodule

// File: rtl/latched_mem_decode.sv
module latched_mem_decode #(
  parameter int ROW_W = 8,
  parameter int COL_W = 2,
  parameter int BLK_W = 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ROW_W+COL_W+BLK_W-1:0]   addr,
  output logic [ROW_W-1:0]               rowIdx,
  output logic [COL_W-1:0]               colIdx,
  output logic [(1<<BLK_W)-1:0]          blkSel
);

  localparam int ADDR_W  = ROW_W + COL_W + BLK_W;
  localparam int NUM_BLK = 1 << BLK_W;

  assign rowIdx = addr[ROW_W-1:0];
  assign colIdx = addr[ROW_W +: COL_W];

  generate
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
      assign blkSel[b] = (addr[ADDR_W-1 -: BLK_W] == BLK_W'(b));
    end
  endgenerate

  AST_ONE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(blkSel)); // R9

endmodule

// File: rtl/latched_mem_datapath.sv
module latched_mem_datapath
  import latched_mem_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 2,
  parameter int BLK_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobeT                   strb,
  input  logic [ROW_W+COL_W+BLK_W-1:0] addrS,
  input  logic [DATA_W-1:0]            dinS,
  output logic [DATA_W-1:0]            rdData
);

  localparam int ADDR_W     = ROW_W + COL_W + BLK_W;
  localparam int NUM_BLK    = 1 << BLK_W;
  localparam int CELL_W     = ROW_W + COL_W;
  localparam int BANK_DEPTH = 1 << CELL_W;

  logic [ADDR_W-1:0]  addrReg;
  logic [DATA_W-1:0]  dataLatch;
  logic [DATA_W-1:0]  rdReg;
  logic [ROW_W-1:0]   rowIdx;
  logic [COL_W-1:0]   colIdx;
  logic [NUM_BLK-1:0] blkSel;
  logic [CELL_W-1:0]  cellIdx;
  logic [DATA_W-1:0]  bankRd [NUM_BLK];
  logic [DATA_W-1:0]  rdMux;

  // Address latch and I/O latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      dataLatch <= '0;
      rdReg     <= '0;
    end else begin
      if (strb.latchAddr)   addrReg   <= addrS;
      if (strb.captureData) dataLatch <= dinS;
      if (strb.readEn)      rdReg     <= rdMux;
    end
  end

  // Early write: the address is taken in the same cycle as the data,
  // the commit one cycle later sees the updated address register.
  latched_mem_decode #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BLK_W(BLK_W)
  ) decode_i (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addrReg),
    .rowIdx (rowIdx),
    .colIdx (colIdx),
    .blkSel (blkSel)
  );

  assign cellIdx = {colIdx, rowIdx};

  generate
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_bank
      logic [DATA_W-1:0] cells [BANK_DEPTH];
      always_ff @(posedge clk) begin
        if (strb.commit && blkSel[b]) cells[cellIdx] <= dataLatch;
      end
      assign bankRd[b] = cells[cellIdx];
    end
  endgenerate

  always_comb begin
    rdMux = '0;
    for (int b = 0; b < NUM_BLK; b++) begin
      if (blkSel[b]) rdMux = rdMux | bankRd[b];
    end
  end

  assign rdData = rdReg;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchAddr |=> $stable(addrReg)); // R2

endmodule

// File: rtl/latched_mem.sv
module latched_mem
  import latched_mem_pkg::*;
#(
  parameter int ROW_W         = 8,
  parameter int COL_W         = 2,
  parameter int BLK_W         = 1,
  parameter int DATA_W        = 8,
  parameter int PRECHARGE_CYC = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         ceN,
  input  logic                         weN,
  input  logic                         oeN,
  input  logic [ROW_W+COL_W+BLK_W-1:0] addr,
  input  logic [DATA_W-1:0]            dqIn,
  output logic [DATA_W-1:0]            dqOut,
  output logic                         dqDrive,
  output logic                         prechargeErr
);

  localparam int ADDR_W = ROW_W + COL_W + BLK_W;
  localparam int BUS_W  = 3 + ADDR_W + DATA_W;
  localparam logic [BUS_W-1:0] BUS_RST = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

  logic [BUS_W-1:0]  pinBus, pinSync;
  logic              ceS, weS, oeS;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dinS, rdData;
  ctrlStrobeT        strb;

  assign pinBus = {ceN, weN, oeN, addr, dqIn};

  latched_mem_sync #(
    .WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)
  ) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinBus),
    .dout (pinSync)
  );

  assign {ceS, weS, oeS, addrS, dinS} = pinSync;

  latched_mem_ctrl #(
    .PRECHARGE_CYC(PRECHARGE_CYC)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .ceS          (ceS),
    .weS          (weS),
    .oeS          (oeS),
    .strb         (strb),
    .dqDrive      (dqDrive),
    .prechargeErr (prechargeErr)
  );

  latched_mem_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BLK_W(BLK_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .addrS  (addrS),
    .dinS   (dinS),
    .rdData (rdData)
  );

  assign dqOut = dqDrive ? rdData : '0;

endmodule

// File: tb/latched_mem_tb_top.sv
`timescale 1ns/1ps
module latched_mem_tb_top;

  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dqIn = '0;
  logic [7:0]    dqOut;
  logic          dqDrive, prechargeErr;

  int testsRun = 0;
  int testsFailed = 0;

  logic [7:0]  refMem [DEPTH];
  logic [7:0]  expQ [$];
  bit          drvQ [$];
  string       tagQ [$];
  event        sampleEv;
  logic [AW-1:0] pool [16];

  always #4 clk = ~clk;

  latched_mem dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqDrive(dqDrive),
    .prechargeErr(prechargeErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectBus(input logic [7:0] e, input bit drv, input string tag);
    expQ.push_back(e);
    drvQ.push_back(drv);
    tagQ.push_back(tag);
    -> sampleEv;
    #1;
  endtask

  // Monitor: pop expected items and compare against the pins
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        logic [7:0] e;
        bit d;
        string t;
        e = expQ.pop_front();
        d = drvQ.pop_front();
        t = tagQ.pop_front();
        if (d) check(dqDrive === 1'b1 && dqOut === e, t, {dqDrive, dqOut}, {1'b1, e});
        else   check(dqDrive === 1'b0, t, dqDrive, 0);
      end
    end
  end

  task automatic idle(input int n);
    ceN = 1'b1; weN = 1'b1;
    cyc(n);
  endtask

  task automatic doRead(input logic [AW-1:0] a, input bit oeHigh, input string tag);
    idle(6);
    addr = a; oeN = oeHigh; ceN = 1'b0;
    cyc(1);
    for (int i = 0; i < 5; i++) begin
      addr = AW'($urandom); cyc(1);
    end
    expectBus(refMem[a], !oeHigh, tag);
    if (oeHigh) begin
      oeN = 1'b0; cyc(6);
      expectBus(refMem[a], 1'b1, {tag, " R7 oe lowered"});
    end
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic lateWrite(input logic [AW-1:0] a, input logic [7:0] d);
    idle(6);
    addr = a; oeN = 1'b0; ceN = 1'b0;
    cyc(2);
    addr = AW'($urandom); dqIn = d; weN = 1'b0;
    cyc(1);
    dqIn = ~d; addr = AW'($urandom);
    cyc(4);
    expectBus(8'h00, 1'b0, "R8 late write no drive");
    refMem[a] = d;
    weN = 1'b1;
    cyc(6);
    expectBus(d, 1'b1, "R5 late write readback");
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic earlyWrite(input logic [AW-1:0] a, input logic [7:0] d);
    idle(6);
    oeN = 1'b0; addr = a; dqIn = d; weN = 1'b0; ceN = 1'b0;
    cyc(1);
    dqIn = ~d; addr = AW'($urandom);
    cyc(5);
    expectBus(8'h00, 1'b0, "R8 early write no drive");
    refMem[a] = d;
    weN = 1'b1;
    cyc(6);
    expectBus(d, 1'b1, "R4 early write readback");
    ceN = 1'b1; oeN = 1'b1;
  endtask

  initial begin
    cyc(4);
    rstN = 1'b1;
    cyc(4);
    check(dqDrive === 1'b0, "R3 reset no drive", dqDrive, 0);
    check(prechargeErr === 1'b0, "R10 reset no error", prechargeErr, 0);

    // R3: standby with oeN low does not drive
    oeN = 1'b0; cyc(8);
    expectBus(8'h00, 1'b0, "R3 standby no drive");
    oeN = 1'b1;

    // R9/R1: addresses differing in one field each
    pool[0] = 11'h000; pool[1] = 11'h001; pool[2] = 11'h080;
    pool[3] = 11'h100; pool[4] = 11'h200; pool[5] = 11'h300;
    pool[6] = 11'h400; pool[7] = 11'h7FF;
    for (int i = 8; i < 16; i++) pool[i] = AW'($urandom);
    for (int i = 0; i < 16; i++) begin
      if (i % 2 == 0) lateWrite(pool[i], 8'(8'h10 + i));
      else            earlyWrite(pool[i], 8'(8'hA0 + i));
    end
    for (int i = 0; i < 8; i++) doRead(pool[i], 1'b0, "R9 field-distinct readback");
    doRead(pool[3], 1'b1, "R7 oe high no drive");

    // R10: too-short precharge, writes attempted in the refused access
    lateWrite(pool[2], 8'h3C);
    ceN = 1'b0; cyc(6);
    ceN = 1'b1; cyc(1);
    addr = pool[2]; dqIn = 8'hC3; weN = 1'b0; oeN = 1'b0; ceN = 1'b0;
    cyc(6);
    check(prechargeErr === 1'b1, "R10 short precharge flagged", prechargeErr, 1);
    weN = 1'b1; cyc(3);
    weN = 1'b0; cyc(3);
    weN = 1'b1; cyc(6);
    expectBus(8'h00, 1'b0, "R10 refused access no drive");
    ceN = 1'b1; oeN = 1'b1; cyc(8);
    check(prechargeErr === 1'b0, "R10 flag cleared", prechargeErr, 0);
    doRead(pool[2], 1'b0, "R10 refused write ignored");

    // R2/R6: random mix
    for (int i = 0; i < 60; i++) begin
      int op;
      int k;
      op = int'($urandom_range(0, 2));
      k = int'($urandom_range(0, 15));
      case (op)
        0: doRead(pool[k], 1'b0, "R6 random read");
        1: lateWrite(pool[k], 8'($urandom));
        default: earlyWrite(pool[k], 8'($urandom));
      endcase
    end
    for (int i = 0; i < 16; i++) doRead(pool[i], 1'b0, "R1 final sweep");

    cyc(4);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 8);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule